// File: doc/BRIEF.md
# Three-Stage Watchdog Timer

This block is one watchdog channel that escalates through up to three stages when software stops servicing it. A 24-bit counter counts down once per prescaled tick, and the tick comes every `DIV` input clocks. When the counter passes zero, that is an expiry: the counter reloads and the expiry stage moves forward. A two-bit mode decides how far the escalation may go. The first stage raises a host interrupt. The second stage raises a management-controller interrupt. The third stage drives a core reset.

Software reaches the block through a simple 64-bit register port. It writes a control word that holds the mode, a 16-bit reload length and the count itself. It keeps the channel alive by writing any value to the poke word. It handles the interrupts through a pending word that is cleared by writing 1, and through separate words that set and clear enable bits.

Top module: `wdt3_top`

## Requirements
- R1: After a synchronous reset, all three outputs are low and the control word and the pending word both read as zero.
- R2: The control word is at byte offset 0x00. Its layout is: mode in bits [1:0], length in bits [19:4], count in bits [43:20], all other bits zero. Writing the control word loads all three fields. Reading it returns the live count.
- R3: While the mode is non-zero, the count drops by one every `DIV` clocks. The tick after the count reaches zero is an expiry, and the count then reloads as {length, 8'hFF}. An expiry therefore happens (count+1)*DIV clocks after a control write or a poke.
- R4: In mode 0 the count is frozen, the prescaler and the stage are cleared, and no expiry occurs.
- R5: In mode 1, every expiry sets the host pending bit, and the stage never advances.
- R6: In modes 2 and 3, the first expiry sets host pending and the second sets management pending. In mode 3 the third expiry and every later one pulse the reset. In mode 2 the second and every later expiry set management pending.
- R7: A write of any data to the poke word at byte offset 0x08 reloads the count as {length, 8'hFF}, clears the prescaler and returns the stage to the first stage.
- R8: The pending word is at byte offset 0x10, with bit 0 for host and bit 1 for management. A pending bit is set on its event even when its enable is off. Writing 1 to a bit clears it. An event in the same cycle as the clear wins over the clear.
- R9: Writing 1s to offset 0x18 sets enable bits, and writing 1s to offset 0x20 clears them. The bit positions match the pending word, and a read of either offset returns the enable mask. Each interrupt output is its pending bit ANDed with its enable bit, registered with one clock of delay.
- R10: With `RST_HOLD`=0 the reset output is a single-clock pulse per reset-stage expiry. With `RST_HOLD`=1 it stays high until the next system reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address; bits above 2 select the word |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, registered one clock after bus_rd |
| host_irq | output | 1 | Host interrupt |
| mgmt_irq | output | 1 | Management-controller interrupt |
| core_rst | output | 1 | Core reset request |

## Verification
The hardest state to reach from the ports is the third stage. Getting there takes two full unserviced expiry periods after the host and management stages, and the management interrupt may be masked while the reset still has to fire. The bench builds the DUT with a divider of 4 and a length of 0, so each stage lasts 1024 clocks. It then walks mode 3 through all three stages with management enabled and again with it disabled. Randomly chosen count values in mode 1 check the expiry instant to the exact clock, and periodic pokes show that the escalation never gets past the first stage.

// File: rtl/wdt3_pkg.sv
package wdt3_pkg;
  localparam int DATA_W   = 64;
  localparam int CNT_W    = 24;
  localparam int LEN_W    = 16;
  localparam int MODE_LSB = 0;
  localparam int LEN_LSB  = 4;
  localparam int CNT_LSB  = 20;

  // word indices (byte offset / 8)
  localparam int W_CTRL = 0;
  localparam int W_POKE = 1;
  localparam int W_PEND = 2;
  localparam int W_ESET = 3;
  localparam int W_ECLR = 4;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_HOST = 2'd1,
    MODE_MGMT = 2'd2,
    MODE_FULL = 2'd3
  } wdt_mode_e;
endpackage

// File: rtl/wdt3_prescale.sv
module wdt3_prescale #(
  parameter int DIV = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst || clear || !run) pre <= '0;
    else if (pre == LAST)     pre <= '0;
    else                      pre <= pre + 1'b1;
  end

  assign tick = run && !clear && (pre == LAST);
endmodule

// File: rtl/wdt3_count.sv
module wdt3_count
  import wdt3_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             poke,
  input  logic [LEN_W-1:0] len,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam int LOW_W = CNT_W - LEN_W;

  logic [CNT_W-1:0] reload;
  assign reload = {len, {LOW_W{1'b1}}};

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else if (poke) count <= reload;
    else if (tick) count <= (count == '0) ? reload : count - 1'b1;
  end

  // tick is already suppressed by load/poke through the prescaler clear
  assign expire = tick && (count == '0);
endmodule

// File: rtl/wdt3_seq.sv
module wdt3_seq
  import wdt3_pkg::*;
#(
  parameter bit RST_HOLD = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       expire,
  input  logic       restart,
  output logic       ev_host,
  output logic       ev_mgmt,
  output logic [1:0] stage,
  output logic       core_rst
);
  logic [1:0] stage_nxt;
  logic       ev_rst;

  always_comb begin
    ev_host   = 1'b0;
    ev_mgmt   = 1'b0;
    ev_rst    = 1'b0;
    stage_nxt = stage;
    if (mode == MODE_OFF || restart) begin
      stage_nxt = 2'd0;
    end else if (expire) begin
      case (wdt_mode_e'(mode))
        MODE_HOST: ev_host = 1'b1;
        MODE_MGMT: begin
          if (stage == 2'd0) begin
            ev_host   = 1'b1;
            stage_nxt = 2'd1;
          end else begin
            ev_mgmt = 1'b1;
          end
        end
        MODE_FULL: begin
          if (stage == 2'd0) begin
            ev_host   = 1'b1;
            stage_nxt = 2'd1;
          end else if (stage == 2'd1) begin
            ev_mgmt   = 1'b1;
            stage_nxt = 2'd2;
          end else begin
            ev_rst = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stage <= 2'd0;
    else     stage <= stage_nxt;
  end

  generate
    if (RST_HOLD) begin : g_hold
      always_ff @(posedge clk) begin
        if (rst) core_rst <= 1'b0;
        else     core_rst <= core_rst | ev_rst;
      end
    end else begin : g_pulse
      always_ff @(posedge clk) begin
        if (rst) core_rst <= 1'b0;
        else     core_rst <= ev_rst;
      end
    end
  endgenerate
endmodule

// File: rtl/wdt3_regs.sv
module wdt3_regs
  import wdt3_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              ev_host,
  input  logic              ev_mgmt,
  output logic [1:0]        mode,
  output logic [LEN_W-1:0]  len,
  output logic              ctrl_load,
  output logic [CNT_W-1:0]  ctrl_cnt,
  output logic              poke,
  output logic [1:0]        pend,
  output logic [1:0]        ena,
  output logic              host_irq,
  output logic              mgmt_irq
);
  localparam int WORD_W = ADDR_W - 3;

  logic [WORD_W-1:0] word;
  logic              wr_pend, wr_eset, wr_eclr;
  logic [1:0]        pend_nxt;
  logic              unused_bits;

  assign word      = bus_addr[ADDR_W-1:3];
  assign ctrl_load = bus_wr && (word == WORD_W'(W_CTRL));
  assign poke      = bus_wr && (word == WORD_W'(W_POKE));
  assign wr_pend   = bus_wr && (word == WORD_W'(W_PEND));
  assign wr_eset   = bus_wr && (word == WORD_W'(W_ESET));
  assign wr_eclr   = bus_wr && (word == WORD_W'(W_ECLR));
  assign ctrl_cnt  = bus_wdata[CNT_LSB +: CNT_W];
  assign unused_bits = ^{bus_wdata[DATA_W-1:CNT_LSB+CNT_W], bus_wdata[3:2], bus_addr[2:0]};

  // an event on the same cycle as a clear keeps the bit set
  assign pend_nxt = (pend & ~(wr_pend ? bus_wdata[1:0] : 2'b00)) | {ev_mgmt, ev_host};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= 2'd0;
      len      <= '0;
      pend     <= 2'b00;
      ena      <= 2'b00;
      host_irq <= 1'b0;
      mgmt_irq <= 1'b0;
    end else begin
      if (ctrl_load) begin
        mode <= bus_wdata[MODE_LSB +: 2];
        len  <= bus_wdata[LEN_LSB +: LEN_W];
      end
      pend <= pend_nxt;
      if (wr_eset)      ena <= ena | bus_wdata[1:0];
      else if (wr_eclr) ena <= ena & ~bus_wdata[1:0];
      host_irq <= pend[0] & ena[0];
      mgmt_irq <= pend[1] & ena[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (word == WORD_W'(W_CTRL))
        bus_rdata <= {{(DATA_W-CNT_LSB-CNT_W){1'b0}}, count, len, 2'b00, mode};
      else if (word == WORD_W'(W_PEND))
        bus_rdata <= {{(DATA_W-2){1'b0}}, pend};
      else if (word == WORD_W'(W_ESET) || word == WORD_W'(W_ECLR))
        bus_rdata <= {{(DATA_W-2){1'b0}}, ena};
      else
        bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/wdt3_top.sv
module wdt3_top
  import wdt3_pkg::*;
#(
  parameter int DIV      = 1024,
  parameter int ADDR_W   = 6,
  parameter bit RST_HOLD = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  output logic              host_irq,
  output logic              mgmt_irq,
  output logic              core_rst
);
  logic [1:0]       mode;
  logic [LEN_W-1:0] len;
  logic             ctrl_load, poke;
  logic [CNT_W-1:0] ctrl_cnt, count;
  logic [1:0]       pend, ena, stage;
  logic             tick, expire, ev_host, ev_mgmt;

  wdt3_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count(count), .ev_host(ev_host), .ev_mgmt(ev_mgmt),
    .mode(mode), .len(len), .ctrl_load(ctrl_load), .ctrl_cnt(ctrl_cnt),
    .poke(poke), .pend(pend), .ena(ena),
    .host_irq(host_irq), .mgmt_irq(mgmt_irq)
  );

  wdt3_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .run(mode != 2'd0),
    .clear(poke || ctrl_load), .tick(tick)
  );

  wdt3_count u_cnt (
    .clk(clk), .rst(rst), .load(ctrl_load), .load_val(ctrl_cnt),
    .poke(poke), .len(len), .tick(tick), .count(count), .expire(expire)
  );

  wdt3_seq #(.RST_HOLD(RST_HOLD)) u_seq (
    .clk(clk), .rst(rst), .mode(mode), .expire(expire), .restart(poke),
    .ev_host(ev_host), .ev_mgmt(ev_mgmt), .stage(stage), .core_rst(core_rst)
  );
endmodule

// File: rtl/wdt3_checker.sv
module wdt3_checker #(
  parameter bit RST_HOLD = 1'b0
) (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  mode,
  input logic [23:0] count,
  input logic        ctrl_load,
  input logic        poke,
  input logic [1:0]  stage,
  input logic [1:0]  pend,
  input logic        core_rst
);
  p_stop_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && !ctrl_load && !poke) |=> $stable(count));

  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'd0 && !ctrl_load && !poke && count != 24'd0) |=>
      (count == $past(count) || count == $past(count) - 24'd1));

  p_poke_restart_r7: assert property (@(posedge clk) disable iff (rst)
    poke |=> (stage == 2'd0));

  p_stage_range_r6: assert property (@(posedge clk) disable iff (rst)
    stage != 2'd3);

  p_rst_only_full_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(core_rst) |-> (mode == 2'd3));

  p_mgmt_needs_mode_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pend[1]) |-> mode[1]);

  generate
    if (RST_HOLD) begin : g_hold
      p_rst_held_r10: assert property (@(posedge clk) disable iff (rst)
        core_rst |=> core_rst);
    end else begin : g_pulse
      p_rst_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        core_rst |=> !core_rst);
    end
  endgenerate
endmodule

bind wdt3_top wdt3_checker #(.RST_HOLD(RST_HOLD)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .count(count), .ctrl_load(ctrl_load),
  .poke(poke), .stage(stage), .pend(pend), .core_rst(core_rst)
);

// File: tb/tb_wdt3_top.sv
module tb_wdt3_top;
  localparam int DIV = 4;
  localparam logic [5:0] A_CTRL = 6'h00, A_POKE = 6'h08, A_PEND = 6'h10,
                         A_ESET = 6'h18, A_ECLR = 6'h20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        host_irq, mgmt_irq, core_rst;

  int checks = 0, fails = 0;
  int rst_rises = 0, rst_high = 0;
  logic rst_prev = 1'b0;

  always #2 clk = ~clk;

  wdt3_top #(.DIV(DIV), .ADDR_W(6), .RST_HOLD(1'b0)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .host_irq(host_irq), .mgmt_irq(mgmt_irq), .core_rst(core_rst)
  );

  always @(negedge clk) begin
    if (core_rst && !rst_prev) rst_rises++;
    if (core_rst) rst_high++;
    rst_prev <= core_rst;
  end

  function automatic logic [63:0] ctrl_word(input logic [1:0] m, input logic [15:0] l,
                                            input logic [23:0] c);
    return {20'b0, c, l, 2'b00, m};
  endfunction

  function automatic int expiry_cycles(input int cnt);
    return (cnt + 1) * DIV;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [63:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [63:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiesce();
    wr(A_CTRL, ctrl_word(2'd0, 16'd0, 24'd0));
    wr(A_PEND, 64'h3);
    step(2);
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] d;
    int r0, c, e;
    r0 = $urandom(32'h5EED);
    step(4);
    rst = 1'b0;
    step(1);

    // R1 reset state
    chk(!host_irq && !mgmt_irq && !core_rst, "R1 outputs",
        {host_irq, mgmt_irq, core_rst}, 0);
    rd(A_CTRL, d); chk(d == 64'd0, "R1 ctrl", d, 0);
    rd(A_PEND, d); chk(d == 64'd0, "R1 pend", d, 0);

    // R2 control layout readback while stopped; R4 frozen in mode 0
    wr(A_CTRL, ctrl_word(2'd0, 16'hA5C3, 24'h123456));
    step(3000);
    rd(A_CTRL, d);
    chk(d == ctrl_word(2'd0, 16'hA5C3, 24'h123456), "R2/R4 ctrl frozen", d,
        ctrl_word(2'd0, 16'hA5C3, 24'h123456));
    chk(!host_irq && !mgmt_irq && rst_rises == 0, "R4 no event in mode 0",
        {host_irq, mgmt_irq}, 0);

    // R9 enable set/clear readback
    wr(A_ESET, 64'h3); rd(A_ESET, d); chk(d == 64'h3, "R9 eset", d, 3);
    wr(A_ECLR, 64'h2); rd(A_ECLR, d); chk(d == 64'h1, "R9 eclr", d, 1);

    // R3 live count after poke: 9 ticks taken from {2,FF}
    wr(A_CTRL, ctrl_word(2'd1, 16'd2, 24'd0));
    wr(A_POKE, 64'h0);
    step(39);
    rd(A_CTRL, d);
    chk(d[43:20] == 24'h2F6, "R3 live count", d[43:20], 24'h2F6);
    quiesce();

    // R3 random counts in mode 1, exact expiry instant
    for (int i = 0; i < 6; i++) begin
      c = $urandom_range(0, 400);
      e = expiry_cycles(c);
      quiesce();
      wr(A_CTRL, ctrl_word(2'd1, 16'd0, c[23:0]));
      step(e - 2);
      chk(!host_irq, "R3 before expiry", host_irq, 0);
      step(4);
      chk(host_irq, "R3 at expiry", host_irq, 1);
    end
    quiesce();

    // R5 mode 1 repeats host, never escalates
    wr(A_ESET, 64'h3);
    wr(A_CTRL, ctrl_word(2'd1, 16'd0, 24'd0));
    wr(A_POKE, 64'h0);
    step(1028);
    chk(host_irq, "R5 first expiry", host_irq, 1);
    wr(A_PEND, 64'h1);
    step(2);
    chk(!host_irq, "R8 w1c clears host", host_irq, 0);
    step(1020);
    chk(host_irq, "R5 second expiry host again", host_irq, 1);
    step(1100);
    rd(A_PEND, d);
    chk(d == 64'h1 && !mgmt_irq && rst_rises == 0, "R5 no escalation", d, 1);
    quiesce();

    // R8 pending set with enable off, R9 gating
    wr(A_ECLR, 64'h3);
    wr(A_CTRL, ctrl_word(2'd1, 16'd0, 24'd0));
    wr(A_POKE, 64'h0);
    step(1030);
    chk(!host_irq, "R9 masked irq", host_irq, 0);
    rd(A_PEND, d); chk(d[0], "R8 pending while disabled", d, 1);
    wr(A_ESET, 64'h1);
    step(2);
    chk(host_irq, "R9 enable exposes pending", host_irq, 1);
    quiesce();

    // R6 mode 3 full sequence, R10 pulse
    wr(A_ESET, 64'h3);
    r0 = rst_rises;
    wr(A_CTRL, ctrl_word(2'd3, 16'd0, 24'd0));
    wr(A_POKE, 64'h0);
    step(1020); chk(!host_irq, "R6 host early", host_irq, 0);
    step(8);    chk(host_irq, "R6 host stage", host_irq, 1);
    step(1016); chk(!mgmt_irq, "R6 mgmt early", mgmt_irq, 0);
    step(8);    chk(mgmt_irq, "R6 mgmt stage", mgmt_irq, 1);
    c = rst_high;
    step(1016); chk(rst_rises == r0, "R6 reset early", rst_rises, r0);
    step(8);
    chk(rst_rises == r0 + 1, "R6 reset stage", rst_rises, r0 + 1);
    chk(rst_high == c + 1, "R10 one-cycle pulse", rst_high, c + 1);
    quiesce();

    // R6 mode 3 with management masked: no mgmt irq, reset still fires
    wr(A_ECLR, 64'h2);
    r0 = rst_rises;
    wr(A_CTRL, ctrl_word(2'd3, 16'd0, 24'd0));
    wr(A_POKE, 64'h0);
    step(2060);
    chk(!mgmt_irq, "R6 masked mgmt", mgmt_irq, 0);
    rd(A_PEND, d); chk(d[1], "R8 mgmt pending masked", d, 2);
    step(1030);
    chk(rst_rises == r0 + 1, "R6 reset with mgmt masked", rst_rises, r0 + 1);
    quiesce();

    // R6 mode 2 stays at management stage
    wr(A_ESET, 64'h3);
    r0 = rst_rises;
    wr(A_CTRL, ctrl_word(2'd2, 16'd0, 24'd0));
    wr(A_POKE, 64'h0);
    step(2060);
    wr(A_PEND, 64'h2);
    step(2);
    chk(!mgmt_irq, "R8 mgmt cleared", mgmt_irq, 0);
    step(1030);
    chk(mgmt_irq && rst_rises == r0, "R6 mode 2 repeats mgmt", mgmt_irq, 1);
    quiesce();

    // R7 periodic pokes keep the channel at stage 1
    r0 = rst_rises;
    wr(A_CTRL, ctrl_word(2'd3, 16'd0, 24'd0));
    for (int i = 0; i < 5; i++) begin
      wr(A_POKE, 64'h0);
      step(900);
    end
    chk(!host_irq && !mgmt_irq && rst_rises == r0, "R7 pokes hold off",
        {host_irq, mgmt_irq}, 0);
    // R7 poke after first expiry restarts at host stage
    step(200);
    wr(A_PEND, 64'h3);
    wr(A_POKE, 64'h0);
    step(1030);
    rd(A_PEND, d);
    chk(d == 64'h1, "R7 restart to host stage", d, 1);
    quiesce();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule